// File: doc/BRIEF.md
# Daisy-Chain Serial Slot Relay

This block is the serial-port slot logic of one device in a chain of identical devices that share a single serial data line. All devices run on the same serial bit clock. A frame sync marks the first bit of a frame. The device that sees the sync takes the 16 bit periods that start with that bit as its own slot. During the slot it samples the input line and drives its transmit word onto the output line. In the bit period after its slot it can raise a one-cycle derived sync, so that the next device in the chain takes the following 16 bits. A chain of N devices therefore shares a frame of 16·N bits.

The block also tracks the type of each frame. It measures the number of bit clocks between successive data-frame syncs. A sync that lands exactly at the control-frame offset is a control frame. That offset is half of the measured period, or a quarter of it when `ctrl_at_quarter` is set. A measured period outside 96..256 bit clocks raises an error. In chained operation, software may not request control frames: such a request is rejected and flagged. A standalone device accepts such a request and treats its next frame as a control frame.

Top module: `dcr_slot_relay`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rx_valid`, `fsync_out`, `period_err` and `sw_ctrl_err` are 0. `sdata_oe` is 0 while `fsync_in` is low.
- R2: A sync accepted in cycle t marks bit 0 of the slot. `sdata_in` is sampled in cycles t..t+15 and the first bit sampled is the MSB. The word appears on `rx_word` with `rx_valid` high for exactly cycle t+16.
- R3: `fsync_out` is high for one cycle, cycle t+16, and only when `chain_en` is high. Otherwise it stays 0. Chained devices therefore occupy consecutive 16-bit slots.
- R4: `tx_word` is captured in cycle t and placed on `sdata_out` MSB first over cycles t..t+15. `sdata_oe` is 1 in exactly those cycles, so at most one device in a chain drives the line at a time.
- R5: A high `fsync_in` that arrives while a slot is in progress is ignored. It neither restarts the slot nor produces a second word.
- R6: A sync is classified as a control frame (`rx_ctrl`=1) when it arrives exactly P/2 bit clocks after the last data sync, or P/4 bit clocks when `ctrl_at_quarter`=1. P is the last measured period. Every other sync is a data frame (`rx_ctrl`=0). The first sync after reset, and the first sync after `chain_en` rises, is always data.
- R7: At each data sync that has an earlier data sync, the count between the two syncs is checked. From the next cycle, `period_err` holds 1 if that count lies outside 96..256 inclusive, and 0 if it lies inside. Control syncs leave `period_err` unchanged.
- R8: If `sw_ctrl_req` is high while `chain_en` is high, `sw_ctrl_err` is 1 in the next cycle. The request has no effect on frame classification.
- R9: If `sw_ctrl_req` is high while `chain_en` is low, the next accepted sync is classified as a control frame.
- R10: With a 256-clock period, eight chained devices all receive their own words when the control sync sits at half the period. Four chained devices do so when it sits at a quarter of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock; one bit period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync_in | input | 1 | Incoming frame sync, high during the first bit of the slot |
| sdata_in | input | 1 | Shared serial data from the host |
| chain_en | input | 1 | Enables the derived sync toward the next device |
| ctrl_at_quarter | input | 1 | 0: control sync at half the period; 1: at a quarter |
| sw_ctrl_req | input | 1 | Software request for a control frame |
| tx_word | input | 16 | Word sent in this device's slot |
| fsync_out | output | 1 | Derived sync for the next device |
| sdata_out | output | 1 | Serial data toward the host |
| sdata_oe | output | 1 | Output enable for `sdata_out` |
| rx_word | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |
| rx_ctrl | output | 1 | 1 when the last word came in a control frame |
| period_err | output | 1 | Last measured period was out of range |
| sw_ctrl_err | output | 1 | A software control request was rejected |

## Verification
Frame classification and period measurement both act in the cycle a sync is accepted. When a control sync arrives, it must be recognised and must also be kept out of the period count. The bench provokes this with the four-device, quarter-period case: there the control sync comes only 64 clocks after the data sync, so counting it as a data sync would set `period_err`. After every frame, including the control frame, the bench checks `period_err` at the last device of the chain. It also checks `rx_ctrl` against the frame type it scheduled.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int unsigned SLOT_BITS   = 16;
    localparam int unsigned SLOT_IDX_W  = $clog2(SLOT_BITS);
    localparam int unsigned PER_MIN_DEF = 96;
    localparam int unsigned PER_MAX_DEF = 256;

    typedef enum logic {
        FRAME_DATA = 1'b0,
        FRAME_CTRL = 1'b1
    } frame_kind_e;

    typedef struct packed {
        logic                  active;
        logic [SLOT_IDX_W-1:0] idx;
        frame_kind_e           kind;
    } slot_ctl_t;

    typedef struct packed {
        logic [SLOT_BITS-1:0] word;
        frame_kind_e          kind;
    } slot_result_t;

    function automatic logic count_in_window(input int unsigned n,
                                             input int unsigned lo,
                                             input int unsigned hi);
        return (n >= lo) && (n <= hi);
    endfunction

    function automatic int unsigned ctrl_offset(input int unsigned per,
                                                input logic quarter);
        return quarter ? (per >> 2) : (per >> 1);
    endfunction

endpackage

// File: rtl/dcr_frame_tracker.sv
module dcr_frame_tracker
    import dcr_pkg::*;
#(
    parameter int unsigned PER_MIN = PER_MIN_DEF,
    parameter int unsigned PER_MAX = PER_MAX_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fs_start,
    input  logic        chain_en,
    input  logic        quarter,
    input  logic        sw_req,
    output frame_kind_e kind,
    output logic        period_err,
    output logic        sw_err
);

    localparam int unsigned CW = $clog2(PER_MAX + 1) + 1;
    localparam logic [CW-1:0] POS_SAT = '1;

    logic [CW-1:0] pos;
    logic [CW-1:0] last_per;
    logic [CW-1:0] ctrl_pos;
    logic          have_ref;
    logic          have_per;
    logic          pend_sw;
    logic          chain_en_q;
    logic          en_rise;
    logic          at_ctrl;
    logic          is_ctrl;
    logic          fs_data;

    always_comb begin
        en_rise  = chain_en && !chain_en_q;
        ctrl_pos = CW'(ctrl_offset(32'(last_per), quarter));
        at_ctrl  = have_per && (pos == ctrl_pos);
        is_ctrl  = fs_start && !en_rise && (pend_sw || at_ctrl);
        fs_data  = fs_start && !is_ctrl;
        kind     = is_ctrl ? FRAME_CTRL : FRAME_DATA;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos        <= '0;
            last_per   <= '0;
            have_ref   <= 1'b0;
            have_per   <= 1'b0;
            pend_sw    <= 1'b0;
            chain_en_q <= 1'b0;
            period_err <= 1'b0;
            sw_err     <= 1'b0;
        end else begin
            chain_en_q <= chain_en;
            sw_err     <= chain_en && sw_req;

            if (have_ref && pos != POS_SAT) begin
                pos <= pos + CW'(1);
            end

            if (fs_data) begin
                pos      <= CW'(1);
                have_ref <= 1'b1;
                if (have_ref) begin
                    last_per   <= pos;
                    have_per   <= 1'b1;
                    period_err <= !count_in_window(32'(pos), PER_MIN, PER_MAX);
                end
            end

            if (is_ctrl) begin
                pend_sw <= 1'b0;
            end
            if (sw_req && !chain_en) begin
                pend_sw <= 1'b1;
            end

            if (en_rise) begin
                have_ref <= fs_data;
                have_per <= 1'b0;
                pend_sw  <= 1'b0;
            end
        end
    end

    // R7: the error flag moves only after a data sync
    a_r7_err_on_data_sync: assert property (@(posedge clk) disable iff (rst)
        !$stable(period_err) |-> $past(fs_start && kind == FRAME_DATA));

    // R8: a rejection flag needs a request made in chained mode
    a_r8_err_source: assert property (@(posedge clk) disable iff (rst)
        sw_err |-> $past(chain_en && sw_req));

    // R6: the first sync after enabling the chain is data
    a_r6_rise_is_data: assert property (@(posedge clk) disable iff (rst)
        ($rose(chain_en) && fs_start) |-> (kind == FRAME_DATA));

endmodule

// File: rtl/dcr_slot_engine.sv
module dcr_slot_engine
    import dcr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fsync_in,
    input  logic                 sdata_in,
    input  logic                 chain_en,
    input  frame_kind_e          kind_in,
    input  logic [SLOT_BITS-1:0] tx_word,
    output logic                 fs_start,
    output logic                 sdata_out,
    output logic                 sdata_oe,
    output logic                 fsync_out,
    output slot_result_t         rx,
    output logic                 rx_valid
);

    localparam logic [SLOT_IDX_W-1:0] LAST_IDX = SLOT_IDX_W'(SLOT_BITS - 1);

    slot_ctl_t            st;
    logic [SLOT_BITS-1:0] shreg;
    logic [SLOT_BITS-1:0] tx_hold;
    logic [SLOT_BITS-1:0] shifted_in;
    logic                 last_bit;

    always_comb begin
        fs_start   = fsync_in && !st.active;
        last_bit   = st.active && (st.idx == LAST_IDX);
        shifted_in = {shreg[SLOT_BITS-2:0], sdata_in};
        sdata_oe   = fs_start || st.active;
        sdata_out  = fs_start ? tx_word[SLOT_BITS-1] : (st.active && tx_hold[SLOT_BITS-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '{active: 1'b0, idx: '0, kind: FRAME_DATA};
            shreg     <= '0;
            tx_hold   <= '0;
            rx        <= '{word: '0, kind: FRAME_DATA};
            rx_valid  <= 1'b0;
            fsync_out <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            fsync_out <= 1'b0;
            if (fs_start) begin
                st      <= '{active: 1'b1, idx: SLOT_IDX_W'(1), kind: kind_in};
                shreg   <= shifted_in;
                tx_hold <= tx_word << 1;
            end else if (st.active) begin
                shreg   <= shifted_in;
                tx_hold <= tx_hold << 1;
                st.idx  <= st.idx + SLOT_IDX_W'(1);
                if (last_bit) begin
                    st.active <= 1'b0;
                    rx        <= '{word: shifted_in, kind: st.kind};
                    rx_valid  <= 1'b1;
                    fsync_out <= chain_en;
                end
            end
        end
    end

    // R2: a received word is announced for a single cycle
    a_r2_single_valid: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R3: derived sync only when the chain is enabled
    a_r3_needs_enable: assert property (@(posedge clk) disable iff (rst)
        fsync_out |-> $past(chain_en));

    // R3: derived sync directly follows a driven slot bit
    a_r3_follows_slot: assert property (@(posedge clk) disable iff (rst)
        fsync_out |-> $past(sdata_oe));

    // R4: the line is only taken on an incoming sync
    a_r4_oe_opens_on_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(sdata_oe) |-> fsync_in);

endmodule

// File: rtl/dcr_slot_relay.sv
module dcr_slot_relay
    import dcr_pkg::*;
#(
    parameter int unsigned PER_MIN = PER_MIN_DEF,
    parameter int unsigned PER_MAX = PER_MAX_DEF
) (
    input  logic                 sclk,
    input  logic                 rst,
    input  logic                 fsync_in,
    input  logic                 sdata_in,
    input  logic                 chain_en,
    input  logic                 ctrl_at_quarter,
    input  logic                 sw_ctrl_req,
    input  logic [SLOT_BITS-1:0] tx_word,
    output logic                 fsync_out,
    output logic                 sdata_out,
    output logic                 sdata_oe,
    output logic [SLOT_BITS-1:0] rx_word,
    output logic                 rx_valid,
    output logic                 rx_ctrl,
    output logic                 period_err,
    output logic                 sw_ctrl_err
);

    logic         fs_start;
    frame_kind_e  kind;
    slot_result_t rx;

    dcr_frame_tracker #(
        .PER_MIN (PER_MIN),
        .PER_MAX (PER_MAX)
    ) u_tracker (
        .clk        (sclk),
        .rst        (rst),
        .fs_start   (fs_start),
        .chain_en   (chain_en),
        .quarter    (ctrl_at_quarter),
        .sw_req     (sw_ctrl_req),
        .kind       (kind),
        .period_err (period_err),
        .sw_err     (sw_ctrl_err)
    );

    dcr_slot_engine u_engine (
        .clk       (sclk),
        .rst       (rst),
        .fsync_in  (fsync_in),
        .sdata_in  (sdata_in),
        .chain_en  (chain_en),
        .kind_in   (kind),
        .tx_word   (tx_word),
        .fs_start  (fs_start),
        .sdata_out (sdata_out),
        .sdata_oe  (sdata_oe),
        .fsync_out (fsync_out),
        .rx        (rx),
        .rx_valid  (rx_valid)
    );

    assign rx_word = rx.word;
    assign rx_ctrl = (rx.kind == FRAME_CTRL);

endmodule

// File: tb/dcr_slot_relay_bench.sv
module dcr_slot_relay_bench;

    localparam int ND = 8;
    localparam int NV = 6;
    localparam int VN [NV] = '{2, 4, 8, 4, 2, 4};
    localparam int VP [NV] = '{144, 256, 256, 144, 128, 200};
    localparam int VQ [NV] = '{0, 1, 0, 0, 1, 0};

    logic sclk = 1'b0;
    logic rst = 1'b1;
    logic host_fs = 1'b0;
    logic host_sdi = 1'b0;
    logic quarter = 1'b0;
    logic sw_req = 1'b0;
    logic [ND-1:0] ce = '0;
    logic [15:0] txw [ND];
    logic [ND-1:0] fsi, fso, sdo, oe, rxv, rxc, perr, swe;
    logic [15:0] rxw [ND];
    logic [15:0] last_w [ND];
    logic [ND-1:0] last_c;
    int rx_cnt [ND];
    int fso_cnt [ND];
    int checks = 0;
    int fails = 0;
    logic [127:0] hbuf_d, hbuf_c;

    always #5 sclk = ~sclk;

    assign fsi[0] = host_fs;
    for (genvar k = 1; k < ND; k++) begin : g_link
        assign fsi[k] = fso[k-1];
    end

    for (genvar k = 0; k < ND; k++) begin : g_dev
        dcr_slot_relay u_dcr_slot_relay (
            .sclk (sclk), .rst (rst), .fsync_in (fsi[k]), .sdata_in (host_sdi),
            .chain_en (ce[k]), .ctrl_at_quarter (quarter), .sw_ctrl_req (sw_req),
            .tx_word (txw[k]), .fsync_out (fso[k]), .sdata_out (sdo[k]),
            .sdata_oe (oe[k]), .rx_word (rxw[k]), .rx_valid (rxv[k]),
            .rx_ctrl (rxc[k]), .period_err (perr[k]), .sw_ctrl_err (swe[k])
        );
        initial begin
            rx_cnt[k] = 0;
            fso_cnt[k] = 0;
            last_w[k] = '0;
            last_c[k] = 1'b0;
            txw[k] = '0;
        end
        always @(negedge sclk) begin
            if (rxv[k]) begin
                last_w[k] = rxw[k];
                last_c[k] = rxc[k];
                rx_cnt[k] = rx_cnt[k] + 1;
            end
            if (fso[k]) fso_cnt[k] = fso_cnt[k] + 1;
        end
    end

    function automatic logic [15:0] wexp(input int v, input int f, input int k);
        return 16'((k + 1) * 16'h1111) ^ 16'((f + 1) * 16'h0203) ^ 16'(v * 16'h0a50);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic f, input logic d);
        @(negedge sclk);
        host_fs = f;
        host_sdi = d;
    endtask

    task automatic idle(input int n);
        repeat (n) tick(1'b0, 1'b0);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 0; i < 16; i++) tick(i == 0, w[15-i]);
    endtask

    task automatic do_reset();
        @(negedge sclk);
        rst = 1'b1;
        host_fs = 1'b0;
        host_sdi = 1'b0;
        sw_req = 1'b0;
        repeat (3) @(negedge sclk);
        rst = 1'b0;
    endtask

    task automatic run_vector(input int v);
        int n, p, cp, tend, base_rx, base_fs0, base_fsl;
        n = VN[v];
        p = VP[v];
        cp = (VQ[v] != 0) ? p / 4 : p / 2;
        for (int k = 0; k < ND; k++) ce[k] = (k < n - 1);
        quarter = VQ[v][0];
        do_reset();
        base_rx = rx_cnt[n-1];
        base_fs0 = fso_cnt[0];
        base_fsl = fso_cnt[n-1];
        tend = 3 * p + 16 * n + 3;
        for (int c = 0; c < tend; c++) begin
            int f, s, o;
            logic in_c, fsv, bitv;
            in_c = (c >= 2 * p + cp) && (c < 2 * p + cp + 16 * n);
            f = c / p;
            if (f > 3) f = 3;
            s = in_c ? 2 * p + cp : f * p;
            if (in_c) f = 4;
            o = c - s;
            fsv = (o == 0);
            bitv = 1'b0;
            if (o < 16 * n) bitv = wexp(v, f, o / 16)[15 - (o % 16)];
            if (o == 0) for (int k = 0; k < ND; k++) txw[k] = ~wexp(v, f, k);
            tick(fsv, bitv);
            #1;
            chk($countones(oe) <= 1, "R4 single driver", 32'(oe), 32'(0));
            if (o < 16 * n) begin
                if (in_c) hbuf_c[o] = |(oe & sdo);
                else hbuf_d[o] = |(oe & sdo);
            end
            for (int fc = 0; fc < 5; fc++) begin
                int sc;
                sc = (fc == 4) ? 2 * p + cp : fc * p;
                if (c == sc + 16 * n + 1) begin
                    for (int k = 0; k < n; k++) begin
                        logic [15:0] hw;
                        for (int b = 0; b < 16; b++)
                            hw[15-b] = (fc == 4) ? hbuf_c[16*k+b] : hbuf_d[16*k+b];
                        chk(last_w[k] == wexp(v, fc, k), "R2 R10 rx word", 32'(last_w[k]), 32'(wexp(v, fc, k)));
                        chk(last_c[k] == (fc == 4), "R6 frame kind", 32'(last_c[k]), 32'(fc == 4));
                        chk(hw == ~wexp(v, fc, k), "R4 tx word", 32'(hw), 32'(~wexp(v, fc, k)));
                    end
                    chk(perr[n-1] == 1'b0, "R7 period in range", 32'(perr[n-1]), 32'(0));
                end
            end
        end
        chk(rx_cnt[n-1] - base_rx == 5, "R3 last device slots", 32'(rx_cnt[n-1] - base_rx), 32'(5));
        chk(fso_cnt[0] - base_fs0 == 5, "R3 derived sync count", 32'(fso_cnt[0] - base_fs0), 32'(5));
        chk(fso_cnt[n-1] - base_fsl == 0, "R3 end of chain quiet", 32'(fso_cnt[n-1] - base_fsl), 32'(0));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge sclk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        int cnt0;
        repeat (2) @(negedge sclk);
        #1;
        // R1 reset state
        chk(rxv == '0 && fso == '0 && oe == '0, "R1 reset outputs", {rxv, fso, oe}, 32'(0));
        chk(perr == '0 && swe == '0, "R1 reset flags", {perr, swe}, 32'(0));
        @(negedge sclk);
        rst = 1'b0;
        #1;
        chk(rxv == '0 && fso == '0 && perr == '0 && swe == '0, "R1 after release",
            {rxv, fso, perr, swe}, 32'(0));

        for (int v = 0; v < NV; v++) run_vector(v);

        // R7 period boundaries on a single device
        ce = '0;
        quarter = 1'b0;
        do_reset();
        send_word(16'h1234);
        idle(64);
        send_word(16'h2345);
        #1 chk(perr[0] == 1'b1, "R7 period 80", 32'(perr[0]), 32'(1));
        idle(184);
        send_word(16'h3456);
        #1 chk(perr[0] == 1'b0, "R7 period 200", 32'(perr[0]), 32'(0));
        idle(284);
        send_word(16'h4567);
        #1 chk(perr[0] == 1'b1, "R7 period 300", 32'(perr[0]), 32'(1));
        idle(240);
        send_word(16'h5678);
        #1 chk(perr[0] == 1'b0, "R7 period 256", 32'(perr[0]), 32'(0));
        idle(80);
        send_word(16'h6789);
        #1 chk(perr[0] == 1'b0, "R7 period 96", 32'(perr[0]), 32'(0));

        // R8 software request in chained mode is rejected
        ce[0] = 1'b1;
        idle(2);
        @(negedge sclk);
        sw_req = 1'b1;
        @(negedge sclk);
        sw_req = 1'b0;
        #1 chk(swe[0] == 1'b1, "R8 rejection flag", 32'(swe[0]), 32'(1));
        send_word(16'hBEEF);
        tick(1'b0, 1'b0);
        #1;
        chk(rxv[0] && rxw[0] == 16'hBEEF, "R2 word after request", 32'(rxw[0]), 32'hBEEF);
        chk(rxc[0] == 1'b0, "R8 kind unaffected", 32'(rxc[0]), 32'(0));
        chk(fso[0] == 1'b1, "R3 derived sync enabled", 32'(fso[0]), 32'(1));
        chk(swe[0] == 1'b0, "R8 flag cleared", 32'(swe[0]), 32'(0));

        // R9 software request in standalone mode marks a control frame
        ce[0] = 1'b0;
        idle(3);
        @(negedge sclk);
        sw_req = 1'b1;
        @(negedge sclk);
        sw_req = 1'b0;
        idle(5);
        send_word(16'hC0DE);
        tick(1'b0, 1'b0);
        #1;
        chk(rxv[0] && rxc[0] == 1'b1, "R9 control by request", 32'(rxc[0]), 32'(1));
        chk(fso[0] == 1'b0, "R3 derived sync disabled", 32'(fso[0]), 32'(0));

        // R5 sync during a slot is ignored
        idle(5);
        cnt0 = rx_cnt[0];
        begin
            logic [15:0] w5;
            w5 = 16'hA5C3;
            for (int i = 0; i < 16; i++) tick(i == 0 || i == 5, w5[15-i]);
        end
        tick(1'b0, 1'b0);
        #1 chk(rxv[0] && rxw[0] == 16'hA5C3, "R5 word from first sync", 32'(rxw[0]), 32'hA5C3);
        idle(20);
        chk(rx_cnt[0] - cnt0 == 1, "R5 single word", 32'(rx_cnt[0] - cnt0), 32'(1));

        // R6 control position detected at half of a 128 period
        do_reset();
        send_word(16'h0F0F);
        idle(112);
        send_word(16'h1E1E);
        idle(48);
        send_word(16'h2D2D);
        tick(1'b0, 1'b0);
        #1 chk(rxv[0] && rxc[0] == 1'b1, "R6 control at half", 32'(rxc[0]), 32'(1));

        // R6 enabling the chain forces the next frame to data
        do_reset();
        send_word(16'h3C3C);
        idle(112);
        send_word(16'h4B4B);
        @(negedge sclk);
        ce[0] = 1'b1;
        host_fs = 1'b0;
        idle(47);
        send_word(16'h5A5A);
        tick(1'b0, 1'b0);
        #1 chk(rxv[0] && rxc[0] == 1'b0, "R6 data after enable", 32'(rxc[0]), 32'(0));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule